// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of host command words and a bit-level I2C bus engine. It takes one 11-bit command at a time from the head of the transmit command queue. From each command and the current target setting it works out the bus framing: a START with address phase, a RESTART with a fresh address phase, the data byte itself, and an optional STOP. It sends the resulting primitives to the engine one at a time over a request/done handshake. Bytes read from the bus are pushed into the receive queue, one per read command.

The target setting selects plain 7-bit addressing, 10-bit addressing, a general call, or a START-byte preamble. A set of rules stops operations that cannot be framed. A read is illegal under general call. A START byte, a 10-bit read, and any RESTART are illegal while restarts are disabled. Bus failures (NACK, arbitration loss) and a software abort request also end the transfer. In every case the block records a one-hot cause, pulses an abort strobe, and flushes the queue until software clears the cause.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word carries forced-restart in bit 10, stop-after in bit 9, read (1) / write (0) in bit 8 and write data in bits 7:0. The first command on a free bus yields START, then the address byte, then the data op. For 7-bit targets the address byte is {tar[6:0], rw}.
- R2: While the bus is held, a RESTART plus a new address phase precedes a command only if its forced-restart bit is set or its direction differs from the previous command.
- R3: A command with the stop bit gets a STOP right after its byte. A command still queued after that STOP opens a new START.
- R4: When the queue runs dry after a byte without STOP, no request is raised and the bus stays held. The next command continues the transfer without START or RESTART.
- R5: Each read command produces exactly one READ op. Its byte bit 0 is 1 when the command's stop bit is set, asking for a NACK on the last byte. The returned byte is pushed to the receive side the cycle after done.
- R6: Target bit 12 selects 10-bit mode. The first address byte is 0xF0|tar[9:8]<<1 and the second is tar[7:0]. A read then adds a RESTART and the byte 0xF1|tar[9:8]<<1.
- R7: Target bit 11 set with bit 10 clear selects general call, with 0x00 as the address byte. A read command in this mode aborts with cause bit 4 and issues no bus op.
- R8: Target bits 11 and 10 both set select a START byte: START, write 0x01, RESTART, then the normal address phase. An ACK on 0x01 aborts with cause bit 7.
- R9: With restart disabled, a START-byte target aborts with cause bit 9. A 10-bit read, or any RESTART that would be needed, aborts with cause bit 10.
- R10: A NACK aborts with a STOP. The cause bit is 0 for a 7-bit address, 1 for the first 10-bit byte, 2 for later 10-bit bytes, 3 for a data write, and 5 for the general-call byte.
- R11: Arbitration loss on any op aborts with cause bit 12 and issues no STOP.
- R12: A software abort request is taken only while enabled. At the next data-byte boundary or held bus it gives STOP and cause bit 16. The request flag clears once that STOP completes.
- R13: An abort gives a one-cycle abort_o and holds the one-hot cause on abort_src_o until abort_clr_i. Meanwhile queued commands are popped and dropped and no bus op starts.
- R14: bus_req_o stays high with stable op and byte until bus_done_i. Op codes are 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enabled |
| restart_en_i | input | 1 | RESTART allowed |
| tar_i | input | 13 | Target: address 9:0, general-call/start-byte 10, special 11, 10-bit 12 |
| abort_req_i | input | 1 | Software abort request strobe |
| abort_clr_i | input | 1 | Clear the recorded abort cause |
| abort_bit_o | output | 1 | Software abort pending |
| cmd_valid_i | input | 1 | Command queue not empty |
| cmd_i | input | 11 | Head command word |
| cmd_pop_o | output | 1 | Pop the head command |
| rx_push_o | output | 1 | Received byte valid |
| rx_data_o | output | 8 | Received byte |
| bus_req_o | output | 1 | Bus op request |
| bus_op_o | output | 3 | Bus op code |
| bus_byte_o | output | 8 | Write byte, or NACK-last flag for reads |
| bus_done_i | input | 1 | Op complete strobe |
| bus_ack_i | input | 1 | Byte acknowledged |
| bus_arb_lost_i | input | 1 | Arbitration lost during op |
| bus_rdata_i | input | 8 | Byte read from bus |
| abort_o | output | 1 | One-cycle abort strobe |
| abort_src_o | output | 17 | One-hot abort cause |

## Verification
A wrong sequencer state shows up in the op stream sent to the engine. Typical symptoms are a missing or extra RESTART, a START where the bus should stay held, or a wrong address byte. Each of these becomes visible at the next request, within a few cycles of the previous done. Wrong rule or abort decisions show up as a wrong cause bit on abort_src_o, or as commands that are executed instead of dropped. A lost or misplaced read shows up in the receive push stream the cycle after the READ completes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_RESTART = 3'd1, OP_STOP = 3'd2, OP_WRITE = 3'd3, OP_READ = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SBYTE, S_SB_RS, S_ADDR1, S_ADDR2, S_A10_RS, S_A10_HI,
    S_DATA, S_HOLD, S_RESTART, S_STOP
  } seq_state_e;

  localparam int CAUSE_W   = 17;
  localparam int C_NACK7   = 0;
  localparam int C_NACK10A = 1;
  localparam int C_NACK10B = 2;
  localparam int C_NACKD   = 3;
  localparam int C_GCREAD  = 4;
  localparam int C_GCNACK  = 5;
  localparam int C_SBACK   = 7;
  localparam int C_NORS_SB = 9;
  localparam int C_NORS_10 = 10;
  localparam int C_ARB     = 12;
  localparam int C_USER    = 16;
endpackage

// File: rtl/i2c_seq_rules.sv
module i2c_seq_rules
  import i2c_seq_pkg::*;
(
  input  logic               fresh_i,
  input  logic               need_rs_i,
  input  logic               rd_i,
  input  logic               ten_i,
  input  logic               gc_i,
  input  logic               sbyte_i,
  input  logic               ren_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    if (gc_i && rd_i)                            cause_o[C_GCREAD]  = 1'b1;
    else if (fresh_i && sbyte_i && !ren_i)       cause_o[C_NORS_SB] = 1'b1;
    else if (fresh_i && ten_i && rd_i && !ren_i) cause_o[C_NORS_10] = 1'b1;
    else if (!fresh_i && need_rs_i && !ren_i)    cause_o[C_NORS_10] = 1'b1;
  end
endmodule

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  seq_state_e    state_i,
  input  logic [9:0]    addr_i,
  input  logic          ten_i,
  input  logic          gc_i,
  input  logic          rd_i,
  output logic [DW-1:0] byte_o
);
  localparam logic [4:0] TEN_HDR = 5'b11110;
  logic [7:0] b8;

  always_comb begin
    unique case (state_i)
      S_SBYTE:  b8 = 8'h01;
      S_ADDR1:  b8 = gc_i  ? 8'h00 :
                     ten_i ? {TEN_HDR, addr_i[9:8], 1'b0} : {addr_i[6:0], rd_i};
      S_ADDR2:  b8 = addr_i[7:0];
      S_A10_HI: b8 = {TEN_HDR, addr_i[9:8], 1'b1};
      default:  b8 = 8'h00;
    endcase
  end
  assign byte_o = DW'(b8);
endmodule

// File: rtl/i2c_seq_abort.sv
module i2c_seq_abort
  import i2c_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               req_i,
  input  logic               user_ack_i,
  input  logic               clr_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               abort_bit_o,
  output logic               abort_o,
  output logic [CAUSE_W-1:0] src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_bit_o <= 1'b0;
      abort_o     <= 1'b0;
      src_o       <= '0;
    end else begin
      if (user_ack_i)             abort_bit_o <= 1'b0;
      else if (req_i && enable_i) abort_bit_o <= 1'b1;
      abort_o <= |cause_i;
      if (|cause_i)   src_o <= cause_i;
      else if (clr_i) src_o <= '0;
    end
  end

  p_req_needs_enable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_bit_o) |-> $past(enable_i));
  p_abort_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  p_cause_held_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_o) && !clr_i |=> (|src_o));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = DW + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               restart_en_i,
  input  logic [12:0]        tar_i,
  input  logic               abort_req_i,
  input  logic               abort_clr_i,
  output logic               abort_bit_o,
  input  logic               cmd_valid_i,
  input  logic [CW-1:0]      cmd_i,
  output logic               cmd_pop_o,
  output logic               rx_push_o,
  output logic [DW-1:0]      rx_data_o,
  output logic               bus_req_o,
  output logic [2:0]         bus_op_o,
  output logic [DW-1:0]      bus_byte_o,
  input  logic               bus_done_i,
  input  logic               bus_ack_i,
  input  logic               bus_arb_lost_i,
  input  logic [DW-1:0]      bus_rdata_i,
  output logic               abort_o,
  output logic [CAUSE_W-1:0] abort_src_o
);
  seq_state_e state_q, nxt;
  logic dir_q, dir_load, user_ack, push;
  logic [CAUSE_W-1:0] cause, rule_cause;
  logic [DW-1:0] addr_byte;

  wire cmd_rd   = cmd_i[DW];
  wire cmd_stop = cmd_i[DW+1];
  wire cmd_frc  = cmd_i[DW+2];
  wire ten      = tar_i[12];
  wire gc       = tar_i[11] & ~tar_i[10];
  wire sbyte    = tar_i[11] & tar_i[10];
  wire locked   = |abort_src_o;
  wire need_rs  = cmd_frc | (cmd_rd != dir_q);

  i2c_seq_rules u_rules (
    .fresh_i(state_q == S_IDLE), .need_rs_i(need_rs), .rd_i(cmd_rd), .ten_i(ten),
    .gc_i(gc), .sbyte_i(sbyte), .ren_i(restart_en_i), .cause_o(rule_cause)
  );

  i2c_seq_addr #(.DW(DW)) u_addr (
    .state_i(state_q), .addr_i(tar_i[9:0]), .ten_i(ten), .gc_i(gc), .rd_i(dir_q),
    .byte_o(addr_byte)
  );

  i2c_seq_abort u_abort (
    .clk_i, .rst_ni, .enable_i, .req_i(abort_req_i), .user_ack_i(user_ack),
    .clr_i(abort_clr_i), .cause_i(cause), .abort_bit_o, .abort_o, .src_o(abort_src_o)
  );

  always_comb begin
    nxt = state_q; cause = '0; cmd_pop_o = 1'b0;
    user_ack = 1'b0; dir_load = 1'b0; push = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (abort_bit_o) begin
          cause[C_USER] = 1'b1; user_ack = 1'b1;
        end else if (locked) begin
          cmd_pop_o = cmd_valid_i;            // flush while cause is held
        end else if (cmd_valid_i && enable_i) begin
          if (|rule_cause) cause = rule_cause;
          else begin nxt = S_START; dir_load = 1'b1; end
        end
      end
      S_HOLD: begin
        if (abort_bit_o) begin
          cause[C_USER] = 1'b1; nxt = S_STOP;
        end else if (cmd_valid_i) begin
          if (|rule_cause) begin cause = rule_cause; nxt = S_STOP; end
          else if (need_rs) begin nxt = S_RESTART; dir_load = 1'b1; end
          else nxt = S_DATA;
        end
      end
      default: if (bus_done_i) begin
        if (bus_arb_lost_i && state_q != S_STOP) begin
          cause[C_ARB] = 1'b1; nxt = S_IDLE;  // bus lost: no STOP
        end else begin
          unique case (state_q)
            S_START:   nxt = sbyte ? S_SBYTE : S_ADDR1;
            S_SBYTE:   if (bus_ack_i) begin cause[C_SBACK] = 1'b1; nxt = S_STOP; end
                       else nxt = S_SB_RS;
            S_SB_RS, S_RESTART: nxt = S_ADDR1;
            S_ADDR1: begin
              if (!bus_ack_i) begin
                cause[gc ? C_GCNACK : (ten ? C_NACK10A : C_NACK7)] = 1'b1;
                nxt = S_STOP;
              end else nxt = (ten && !gc) ? S_ADDR2 : S_DATA;
            end
            S_ADDR2: if (!bus_ack_i) begin cause[C_NACK10B] = 1'b1; nxt = S_STOP; end
                     else nxt = dir_q ? S_A10_RS : S_DATA;
            S_A10_RS: nxt = S_A10_HI;
            S_A10_HI: if (!bus_ack_i) begin cause[C_NACK10B] = 1'b1; nxt = S_STOP; end
                      else nxt = S_DATA;
            S_DATA: begin
              if (!dir_q && !bus_ack_i) begin
                cause[C_NACKD] = 1'b1; nxt = S_STOP;
              end else begin
                cmd_pop_o = 1'b1; push = dir_q;
                if (abort_bit_o) begin cause[C_USER] = 1'b1; nxt = S_STOP; end
                else nxt = cmd_stop ? S_STOP : S_HOLD;
              end
            end
            S_STOP: begin nxt = S_IDLE; user_ack = abort_bit_o; end
            default: nxt = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    bus_req_o  = (state_q != S_IDLE) && (state_q != S_HOLD);
    bus_byte_o = addr_byte;
    unique case (state_q)
      S_START:                       bus_op_o = OP_START;
      S_SB_RS, S_RESTART, S_A10_RS:  bus_op_o = OP_RESTART;
      S_STOP:                        bus_op_o = OP_STOP;
      S_DATA: begin
        bus_op_o   = dir_q ? OP_READ : OP_WRITE;
        bus_byte_o = dir_q ? {{(DW-1){1'b0}}, cmd_stop} : cmd_i[DW-1:0];
      end
      default:                       bus_op_o = OP_WRITE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      dir_q     <= 1'b0;
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      state_q   <= nxt;
      if (dir_load) dir_q <= cmd_rd;
      rx_push_o <= push;
      if (push) rx_data_o <= bus_rdata_i;
    end
  end

  p_req_stable_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_byte_o));
  p_rx_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(bus_done_i && bus_op_o == OP_READ));
  p_locked_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_src_o) && !abort_clr_i && state_q == S_IDLE |=> !bus_req_o);
  p_stop_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_bit_o && bus_done_i && bus_op_o == OP_STOP |=> !abort_bit_o);
endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic enable = 1, ren = 1, abort_req = 0, abort_clr = 0;
  logic [12:0] tar = 13'h055;
  logic abort_bit, cmd_pop, rx_push, bus_req, abort_o;
  logic [7:0] rx_data, bus_byte, rdata = 0;
  logic [2:0] bus_op;
  logic [16:0] abort_src;
  logic done = 0, ack = 1, arb = 0;
  logic [10:0] cmd_q [256];
  logic [7:0] head = 0, tail = 0;
  wire cmd_valid = head != tail;
  wire [10:0] cmd_w = cmd_q[head];

  i2c_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .restart_en_i(ren), .tar_i(tar),
    .abort_req_i(abort_req), .abort_clr_i(abort_clr), .abort_bit_o(abort_bit),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd_w), .cmd_pop_o(cmd_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .bus_req_o(bus_req), .bus_op_o(bus_op),
    .bus_byte_o(bus_byte), .bus_done_i(done), .bus_ack_i(ack), .bus_arb_lost_i(arb),
    .bus_rdata_i(rdata), .abort_o(abort_o), .abort_src_o(abort_src)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  int op_log [64], by_log [64], log_n = 0;
  int ex_op [64], ex_by [64], exp_n = 0;
  int rx_log [16], rx_n = 0, abort_cnt = 0;
  int nack_idx = -1, arb_idx = -1, wc = 0;
  logic pend = 0;
  logic [16:0] last_src = 0;

  always @(posedge clk) if (cmd_pop) head <= head + 8'd1;

  // bus engine model: log request, answer after two cycles
  always @(negedge clk) begin
    if (done) begin done = 0; ack = 1; arb = 0; end
    else if (pend) begin
      if (wc == 0) begin
        done = 1; pend = 0;
        ack = (log_n - 1) != nack_idx;
        arb = (log_n - 1) == arb_idx;
        rdata = 8'(8'h30 + log_n - 1);
      end else wc--;
    end else if (bus_req && rst_n && log_n < 64) begin
      op_log[log_n] = int'(bus_op); by_log[log_n] = int'(bus_byte);
      log_n++; pend = 1; wc = 1;
    end
  end

  always @(negedge clk) begin
    if (abort_o) begin abort_cnt++; last_src = abort_src; end
    if (rx_push && rx_n < 16) begin rx_log[rx_n] = int'(rx_data); rx_n++; end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic scn(input logic [12:0] t, input logic r, input int nk, input int ar);
    tar = t; ren = r; nack_idx = nk; arb_idx = ar;
    log_n = 0; exp_n = 0; rx_n = 0; abort_cnt = 0;
  endtask

  task automatic pc(input int c);
    cmd_q[tail] = 11'(c); tail = tail + 8'd1;
  endtask

  task automatic ex(input int op, input int b);
    ex_op[exp_n] = op; ex_by[exp_n] = b; exp_n++;
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (bus_req || pend || done) q = 0; else q++;
    end
  endtask

  task automatic check_log(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (op_log[i] != ex_op[i] || by_log[i] != ex_by[i])) bad = i;
    if (log_n != exp_n) chk(0, {tag, " op count"}, log_n, exp_n);
    else if (bad >= 0) chk(0, {tag, " op/byte"}, op_log[bad]*256 + by_log[bad],
                           ex_op[bad]*256 + ex_by[bad]);
    else chk(1, tag, 0, 0);
  endtask

  task automatic check_abort(input string tag, input int src);
    chk(abort_cnt == 1 && int'(last_src) == src, tag, int'(last_src), src);
    chk(head == tail, {tag, " R13 flush"}, int'(tail - head), 0);
    @(negedge clk); abort_clr = 1; @(negedge clk); abort_clr = 0;
    chk(abort_src == 0, {tag, " R13 clear"}, int'(abort_src), 0);
  endtask

  function automatic int a7(input int a, input int rw);
    return ((a & 8'h7f) << 1) | rw;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!bus_req && !abort_o && abort_src == 0 && !cmd_pop, "reset R14", int'(bus_req), 0);
    rst_n = 1; @(negedge clk);

    scn(13'h055, 1, -1, -1); pc('h0AA); pc('h2BB); quiet();
    ex(0,0); ex(3,'hAA); ex(3,'hAA); ex(3,'hBB); ex(2,0); check_log("R1 7-bit write");

    scn(13'h050, 1, -1, -1); pc('h010); pc('h100); pc('h300); quiet();
    ex(0,0); ex(3,'hA0); ex(3,'h10); ex(1,0); ex(3,'hA1); ex(4,0); ex(4,1); ex(2,0);
    check_log("R2 direction change, R5 read nack-last");
    chk(rx_n == 2 && rx_log[0] == 'h35 && rx_log[1] == 'h36, "R5 rx bytes",
        rx_log[0]*256 + rx_log[1], 'h3536);

    scn(13'h050, 1, -1, -1); pc('h011); pc('h622); quiet();
    ex(0,0); ex(3,'hA0); ex(3,'h11); ex(1,0); ex(3,'hA0); ex(3,'h22); ex(2,0);
    check_log("R2 forced restart");

    scn(13'h055, 1, -1, -1); pc('h011); quiet();
    chk(log_n == 3 && !bus_req, "R4 bus held", log_n, 3);
    pc('h222); quiet();
    ex(0,0); ex(3,'hAA); ex(3,'h11); ex(3,'h22); ex(2,0); check_log("R4 continue");

    scn(13'h055, 1, -1, -1); pc('h201); pc('h202); quiet();
    ex(0,0); ex(3,'hAA); ex(3,1); ex(2,0); ex(0,0); ex(3,'hAA); ex(3,2); ex(2,0);
    check_log("R3 stop then new start");

    scn(13'h12A5, 1, -1, -1); pc('h277); quiet();
    ex(0,0); ex(3,'hF4); ex(3,'hA5); ex(3,'h77); ex(2,0); check_log("R6 10-bit write");
    scn(13'h12A5, 1, -1, -1); pc('h300); quiet();
    ex(0,0); ex(3,'hF4); ex(3,'hA5); ex(1,0); ex(3,'hF5); ex(4,1); ex(2,0);
    check_log("R6 10-bit read");

    scn(13'h12A5, 0, -1, -1); pc('h300); pc('h201); quiet();
    check_log("R9 10-bit read no restart"); check_abort("R9 cause bit 10", 'h400);

    scn(13'h0855, 1, -1, -1); pc('h244); quiet();
    ex(0,0); ex(3,0); ex(3,'h44); ex(2,0); check_log("R7 general call write");
    scn(13'h0855, 1, -1, -1); pc('h300); quiet();
    check_log("R7 gc read no ops"); check_abort("R7 cause bit 4", 'h10);

    scn(13'h0C55, 1, 1, -1); pc('h233); quiet();
    ex(0,0); ex(3,1); ex(1,0); ex(3,'hAA); ex(3,'h33); ex(2,0); check_log("R8 start byte");
    scn(13'h0C55, 1, -1, -1); pc('h233); quiet();
    ex(0,0); ex(3,1); ex(2,0); check_log("R8 acked start byte");
    check_abort("R8 cause bit 7", 'h80);
    scn(13'h0C55, 0, -1, -1); pc('h233); quiet();
    check_log("R9 start byte no restart"); check_abort("R9 cause bit 9", 'h200);

    scn(13'h055, 0, -1, -1); pc('h011); pc('h300); quiet();
    ex(0,0); ex(3,'hAA); ex(3,'h11); ex(2,0); check_log("R9 dir change no restart");
    check_abort("R9 dir cause bit 10", 'h400);

    scn(13'h055, 1, 1, -1); pc('h011); pc('h212); quiet();
    ex(0,0); ex(3,'hAA); ex(2,0); check_log("R10 addr nack"); check_abort("R10 bit 0", 1);
    scn(13'h055, 1, 2, -1); pc('h011); pc('h212); quiet();
    ex(0,0); ex(3,'hAA); ex(3,'h11); ex(2,0); check_log("R10 data nack");
    check_abort("R10 bit 3", 8);
    scn(13'h12A5, 1, 1, -1); pc('h211); quiet();
    ex(0,0); ex(3,'hF4); ex(2,0); check_log("R10 10-bit first nack");
    check_abort("R10 bit 1", 2);
    scn(13'h12A5, 1, 2, -1); pc('h211); quiet();
    ex(0,0); ex(3,'hF4); ex(3,'hA5); ex(2,0); check_log("R10 10-bit second nack");
    check_abort("R10 bit 2", 4);
    scn(13'h0800, 1, 1, -1); pc('h211); quiet();
    ex(0,0); ex(3,0); ex(2,0); check_log("R10 gc nack"); check_abort("R10 bit 5", 'h20);

    scn(13'h055, 1, -1, 1); pc('h011); pc('h212); quiet();
    ex(0,0); ex(3,'hAA); check_log("R11 arb lost no stop"); check_abort("R11 bit 12", 'h1000);

    enable = 0; @(negedge clk); abort_req = 1; @(negedge clk); abort_req = 0;
    repeat (3) @(negedge clk);
    chk(!abort_bit && abort_src == 0, "R12 ignored while disabled", int'(abort_bit), 0);
    enable = 1;

    scn(13'h055, 1, -1, -1); pc('h011); quiet();
    abort_req = 1; @(negedge clk); abort_req = 0; quiet();
    ex(0,0); ex(3,'hAA); ex(3,'h11); ex(2,0); check_log("R12 user abort stop");
    chk(!abort_bit, "R12 request clears after stop", int'(abort_bit), 0);
    check_abort("R12 bit 16", 'h10000);

    for (int it = 0; it < 8; it++) begin
      int a = int'($urandom_range(8, 119));
      int n = int'($urandom_range(1, 4));
      scn(13'(a), 1, -1, -1);
      ex(0,0); ex(3, a7(a, 0));
      for (int k = 0; k < n; k++) begin
        int d = int'($urandom_range(0, 255));
        pc(((k == n-1) ? 'h200 : 0) | d); ex(3, d);
      end
      ex(2,0); quiet(); check_log("R1 R3 random write");
    end

    finish_run();
  end
endmodule